// File: doc/BRIEF.md
# Two-Stage Fixed-Point Multiply-Accumulate Datapath

This block is a signed fixed-point multiply-accumulate engine. A multiplicand register (T) and the word on the data input feed a 16×16 signed multiplier. Its 32-bit result is registered into an exposed product register (P) and is not added straight into the accumulator. A later operation adds or subtracts the product held in P into a 32-bit accumulator (A). The accumulator has no guard bits: it wraps modulo 2^32, and a sticky flag records any signed overflow.

Each cycle, a 4-bit opcode chooses the work for that cycle. Several opcodes both start a new product and fold the previous one into A. A stream of multiply-accumulate operations therefore retires one product per cycle, with every product accumulated one cycle after it is formed. A hardware-loop input issues a given number of multiply-accumulate operations on consecutive cycles. During the loop the opcode input is ignored and a new data word is taken each cycle.

Top module: `mac_pipe`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears T, P, A, the overflow flag and any running loop. After reset, accOut, prodOut, ovfFlag and loopBusy are all 0.
- R2: Opcode 1 (load T) copies dataIn into T. It leaves P and A unchanged.
- R3: Opcode 2 (multiply) writes the signed product T×dataIn into P at that edge and leaves A unchanged. For example, T=3 with dataIn=-5 gives 0xFFFFFFF1.
- R4: The most negative operand squared, 0x8000×0x8000, gives P=0x40000000.
- R5: Opcode 3 sets A to A+P and opcode 4 sets A to A−P. Neither changes P.
- R6: Opcode 5 loads dataIn into T and sets A to A+P in the same cycle.
- R7: Opcode 6 sets A to A+P using the old P, writes dataIn×dataIn into P and loads dataIn into T. A product formed this way is never negative.
- R8: Opcode 7 sets A to A−P using the old P, writes dataIn×dataIn into P and loads dataIn into T.
- R9: Opcode 8 sets A to A+P using the old P and writes T×dataIn into P. Issued back to back, it accumulates one product per cycle.
- R10: A wraps modulo 2^32. A signed overflow on an add or a subtract sets ovfFlag. The flag holds until ovfClear is high at an edge. When a new overflow and ovfClear occur in the same cycle, the flag is set.
- R11: If loopStart is high with loopCount=N>0 while no loop is running, the block issues N opcode-8 operations on N consecutive edges, one dataIn word per edge. loopBusy is high after the first N−1 of those edges. The opcode input and loopStart are ignored while the loop runs. loopStart with N=0 does nothing and ignores the opcode.
- R12: Opcode 0 and opcodes 9 to 15 leave T, P, A and ovfFlag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opCode | input | 4 | Operation for this cycle |
| dataIn | input | 16 | Data-bus word, signed |
| loopStart | input | 1 | Starts a hardware multiply-accumulate loop |
| loopCount | input | 8 | Number of loop iterations |
| ovfClear | input | 1 | Clears the sticky overflow flag |
| accOut | output | 32 | Accumulator A |
| prodOut | output | 32 | Product register P |
| ovfFlag | output | 1 | Sticky accumulator overflow flag |
| loopBusy | output | 1 | A hardware loop has iterations left |

## Verification
Every register (T, P, A, the flag and the loop counter) updates at the single rising edge where its operation is presented. A product therefore shows on prodOut after that edge, but it reaches accOut only after the edge of a later accumulating operation. The bench drives each operation after a falling edge and samples just after the next rising edge, so each result is read one register stage after its stimulus. The value of T is never read directly: the bench exposes it by issuing a multiply by 1 and reading P one edge later.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [3:0] {
    OP_IDLE      = 4'd0,
    OP_LOADT     = 4'd1,
    OP_MUL       = 4'd2,
    OP_ACCP      = 4'd3,
    OP_SUBP      = 4'd4,
    OP_LOADT_ACC = 4'd5,
    OP_SQR_ACC   = 4'd6,
    OP_SQR_SUB   = 4'd7,
    OP_MAC       = 4'd8
  } opcode_e;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic tLoad;      // T <= dataIn
    logic prodEn;     // P <= multiplier result
    logic squareSel;  // multiplier operand A is dataIn instead of T
    logic accEn;      // A <= A +/- P
    logic accSub;     // subtract instead of add
  } strobes_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       opCode,
  input  logic             loopStart,
  input  logic [CNT_W-1:0] loopCount,
  output strobes_t         stb,
  output logic             loopBusy
);

  localparam logic [CNT_W-1:0] CntOne  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CntZero = '0;

  logic [CNT_W-1:0] remaining;
  logic             startValid;

  assign loopBusy   = (remaining != CntZero);
  assign startValid = loopStart && (loopCount != CntZero);

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= CntZero;
    end else if (loopBusy) begin
      remaining <= remaining - CntOne;
    end else if (startValid) begin
      remaining <= loopCount - CntOne;
    end
  end

  strobes_t macStb;
  assign macStb = '{tLoad: 1'b0, prodEn: 1'b1, squareSel: 1'b0,
                    accEn: 1'b1, accSub: 1'b0};

  strobes_t opStb;
  always_comb begin
    opStb = '0;
    case (opCode)
      OP_LOADT:     opStb.tLoad = 1'b1;
      OP_MUL:       opStb.prodEn = 1'b1;
      OP_ACCP:      opStb.accEn = 1'b1;
      OP_SUBP: begin
        opStb.accEn  = 1'b1;
        opStb.accSub = 1'b1;
      end
      OP_LOADT_ACC: begin
        opStb.tLoad = 1'b1;
        opStb.accEn = 1'b1;
      end
      OP_SQR_ACC: begin
        opStb.tLoad     = 1'b1;
        opStb.prodEn    = 1'b1;
        opStb.squareSel = 1'b1;
        opStb.accEn     = 1'b1;
      end
      OP_SQR_SUB: begin
        opStb.tLoad     = 1'b1;
        opStb.prodEn    = 1'b1;
        opStb.squareSel = 1'b1;
        opStb.accEn     = 1'b1;
        opStb.accSub    = 1'b1;
      end
      OP_MAC:       opStb = macStb;
      default:      opStb = '0;
    endcase
  end

  always_comb begin
    if (loopBusy || startValid) stb = macStb;
    else if (loopStart)         stb = '0;
    else                        stb = opStb;
  end

  // R11: a loop only begins from a start request
  assert_loop_start_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(loopBusy) |-> $past(loopStart));

  // R11: a loop that has more than one iteration left keeps running
  assert_loop_keeps_R11: assert property (@(posedge clk) disable iff (rst)
    (remaining > CntOne) |=> loopBusy);

endmodule

// File: rtl/mac_dpath.sv
module mac_dpath
  import mac_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  strobes_t              stb,
  input  logic [DATA_W-1:0]     dataIn,
  input  logic                  ovfClear,
  output logic [2*DATA_W-1:0]   accOut,
  output logic [2*DATA_W-1:0]   prodOut,
  output logic                  ovfFlag
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = PROD_W;  // no guard bits
  localparam int MSB    = ACC_W - 1;

  logic signed [DATA_W-1:0] tReg;
  logic signed [PROD_W-1:0] prodReg;
  logic        [ACC_W-1:0]  accReg;
  logic                     ovfReg;

  // Multiplier stage
  logic signed [DATA_W-1:0] mulA;
  logic signed [DATA_W-1:0] mulB;
  logic signed [PROD_W-1:0] mulRes;

  assign mulA   = stb.squareSel ? $signed(dataIn) : tReg;
  assign mulB   = $signed(dataIn);
  assign mulRes = mulA * mulB;

  // Accumulate stage
  logic [ACC_W-1:0] sumAdd;
  logic [ACC_W-1:0] sumSub;
  logic [ACC_W-1:0] accNext;
  logic             ovfAdd;
  logic             ovfSub;
  logic             ovfNow;

  assign sumAdd  = accReg + prodReg;
  assign sumSub  = accReg - prodReg;
  assign accNext = stb.accSub ? sumSub : sumAdd;
  assign ovfAdd  = (accReg[MSB] == prodReg[MSB]) && (sumAdd[MSB] != accReg[MSB]);
  assign ovfSub  = (accReg[MSB] != prodReg[MSB]) && (sumSub[MSB] != accReg[MSB]);
  assign ovfNow  = stb.accEn && (stb.accSub ? ovfSub : ovfAdd);

  always_ff @(posedge clk) begin
    if (rst) begin
      tReg    <= '0;
      prodReg <= '0;
      accReg  <= '0;
      ovfReg  <= 1'b0;
    end else begin
      if (stb.tLoad)  tReg    <= $signed(dataIn);
      if (stb.prodEn) prodReg <= mulRes;
      if (stb.accEn)  accReg  <= accNext;
      if (ovfNow)        ovfReg <= 1'b1;
      else if (ovfClear) ovfReg <= 1'b0;
    end
  end

  assign accOut  = accReg;
  assign prodOut = prodReg;
  assign ovfFlag = ovfReg;

  // R7: a squared product is never negative
  assert_square_sign_R7: assert property (@(posedge clk) disable iff (rst)
    (stb.prodEn && stb.squareSel) |=> !prodReg[PROD_W-1]);

  // R2: T holds when not loaded
  assert_t_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !stb.tLoad |=> $stable(tReg));

endmodule

// File: rtl/mac_pipe.sv
module mac_pipe
  import mac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          opCode,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic                loopStart,
  input  logic [CNT_W-1:0]    loopCount,
  input  logic                ovfClear,
  output logic [2*DATA_W-1:0] accOut,
  output logic [2*DATA_W-1:0] prodOut,
  output logic                ovfFlag,
  output logic                loopBusy
);

  strobes_t stb;

  mac_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .opCode    (opCode),
    .loopStart (loopStart),
    .loopCount (loopCount),
    .stb       (stb),
    .loopBusy  (loopBusy)
  );

  mac_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .dataIn   (dataIn),
    .ovfClear (ovfClear),
    .accOut   (accOut),
    .prodOut  (prodOut),
    .ovfFlag  (ovfFlag)
  );

  logic idleOp;
  assign idleOp = (opCode == 4'd0) || (opCode > 4'd8);

  // R1: reset clears all visible state
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (accOut == '0) && (prodOut == '0) && !ovfFlag && !loopBusy);

  // R12: idle and unused opcodes change nothing
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (idleOp && !loopBusy && !loopStart && !ovfClear) |=>
      ($stable(accOut) && $stable(prodOut) && $stable(ovfFlag)));

  // R10: overflow flag is sticky until cleared
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (ovfFlag && !ovfClear) |=> ovfFlag);

  // R5: accumulate-only opcodes keep P
  assert_accp_keeps_prod_R5: assert property (@(posedge clk) disable iff (rst)
    ((opCode == 4'd3 || opCode == 4'd4) && !loopBusy && !loopStart) |=>
      $stable(prodOut));

endmodule

// File: tb/test_mac_pipe.sv
module test_mac_pipe;

  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] IDLE = 4'd0, LDT = 4'd1, MUL = 4'd2, ACCP = 4'd3,
                         SUBP = 4'd4, LTA = 4'd5, SQA = 4'd6, SQS = 4'd7,
                         MAC = 4'd8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opCode = '0;
  logic [15:0] dataIn = '0;
  logic        loopStart = 1'b0;
  logic [7:0]  loopCount = '0;
  logic        ovfClear = 1'b0;
  logic [31:0] accOut;
  logic [31:0] prodOut;
  logic        ovfFlag;
  logic        loopBusy;

  int checks = 0;
  int errors = 0;

  mac_pipe i_mac_pipe (
    .clk(clk), .rst(rst), .opCode(opCode), .dataIn(dataIn),
    .loopStart(loopStart), .loopCount(loopCount), .ovfClear(ovfClear),
    .accOut(accOut), .prodOut(prodOut), .ovfFlag(ovfFlag), .loopBusy(loopBusy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Present one operation, let one rising edge take it, sample after it
  task automatic step(input logic [3:0] op, input logic [15:0] d, input logic clr = 1'b0);
    @(negedge clk);
    opCode = op; dataIn = d; ovfClear = clr; loopStart = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; opCode = IDLE; loopStart = 1'b0; ovfClear = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic testReset();
    step(LDT, 16'd9);
    step(MUL, 16'd9);
    step(ACCP, 16'd0);
    doReset();
    check("R1 acc", accOut, 32'h0);
    check("R1 prod", prodOut, 32'h0);
    check("R1 ovf", {31'b0, ovfFlag}, 32'h0);
    check("R1 busy", {31'b0, loopBusy}, 32'h0);
    step(MUL, 16'd7);
    check("R1 T cleared", prodOut, 32'h0);
  endtask

  task automatic testLoadMul();
    doReset();
    step(LDT, 16'd3);
    check("R2 prod after load", prodOut, 32'h0);
    step(MUL, 16'hFFFB);
    check("R3 product", prodOut, 32'hFFFFFFF1);
    check("R3 acc unchanged", accOut, 32'h0);
    step(LDT, 16'd7);
    check("R2 prod kept", prodOut, 32'hFFFFFFF1);
    check("R2 acc kept", accOut, 32'h0);
    step(MUL, 16'd1);
    check("R2 T loaded", prodOut, 32'h7);
  endtask

  task automatic testCorner();
    doReset();
    step(LDT, 16'h8000);
    step(MUL, 16'h8000);
    check("R4 min squared", prodOut, 32'h40000000);
    step(LDT, 16'h7FFF);
    step(MUL, 16'h8000);
    check("R4 max times min", prodOut, 32'hC0008000);
  endtask

  task automatic testAccSub();
    doReset();
    step(LDT, 16'h8000);
    step(MUL, 16'h8000);
    step(ACCP, 16'd0);
    check("R5 add", accOut, 32'h40000000);
    check("R5 prod kept add", prodOut, 32'h40000000);
    step(SUBP, 16'd0);
    check("R5 sub to zero", accOut, 32'h0);
    step(SUBP, 16'd0);
    check("R5 sub negative", accOut, 32'hC0000000);
    check("R5 prod kept sub", prodOut, 32'h40000000);
  endtask

  task automatic testLoadAcc();
    doReset();
    step(LDT, 16'd2);
    step(MUL, 16'd10);
    step(LTA, 16'd4);
    check("R6 acc", accOut, 32'd20);
    check("R6 prod kept", prodOut, 32'd20);
    step(MUL, 16'd3);
    check("R6 T loaded", prodOut, 32'd12);
  endtask

  task automatic testSquare();
    doReset();
    step(SQA, 16'd7);
    check("R7 acc old P", accOut, 32'd0);
    check("R7 square", prodOut, 32'd49);
    step(SQA, 16'hFFFD);
    check("R7 acc", accOut, 32'd49);
    check("R7 neg square", prodOut, 32'd9);
    step(SQS, 16'd2);
    check("R8 acc", accOut, 32'd40);
    check("R8 square", prodOut, 32'd4);
    step(MUL, 16'd1);
    check("R8 T loaded", prodOut, 32'd2);
  endtask

  task automatic testMacStream();
    doReset();
    step(LDT, 16'd3);
    step(MAC, 16'd1);
    check("R9 acc c1", accOut, 32'd0);
    check("R9 prod c1", prodOut, 32'd3);
    step(MAC, 16'd2);
    check("R9 acc c2", accOut, 32'd3);
    check("R9 prod c2", prodOut, 32'd6);
    step(MAC, 16'hFFFC);
    check("R9 acc c3", accOut, 32'd9);
    check("R9 prod c3", prodOut, 32'hFFFFFFF4);
    step(ACCP, 16'd0);
    check("R9 drain", accOut, 32'hFFFFFFFD);
  endtask

  task automatic testOverflow();
    doReset();
    step(LDT, 16'h4000);
    step(MUL, 16'h4000);
    for (int i = 0; i < 7; i++) step(ACCP, 16'd0);
    check("R10 no ovf yet", {31'b0, ovfFlag}, 32'h0);
    check("R10 acc 7", accOut, 32'h70000000);
    step(ACCP, 16'd0);
    check("R10 wrap", accOut, 32'h80000000);
    check("R10 ovf set", {31'b0, ovfFlag}, 32'h1);
    step(IDLE, 16'd0);
    check("R10 sticky", {31'b0, ovfFlag}, 32'h1);
    step(IDLE, 16'd0, 1'b1);
    check("R10 cleared", {31'b0, ovfFlag}, 32'h0);
    step(SUBP, 16'd0, 1'b1);
    check("R10 sub wrap", accOut, 32'h70000000);
    check("R10 set wins", {31'b0, ovfFlag}, 32'h1);
  endtask

  task automatic testIdle();
    doReset();
    step(LDT, 16'd5);
    step(MUL, 16'd2);
    step(ACCP, 16'd0);
    for (int op = 0; op < 16; op++) begin
      if (op == 0 || op > 8) begin
        step(4'(op), 16'h1234);
        check($sformatf("R12 acc op%0d", op), accOut, 32'd10);
        check($sformatf("R12 prod op%0d", op), prodOut, 32'd10);
      end
    end
    step(MUL, 16'd1);
    check("R12 T kept", prodOut, 32'd5);
  endtask

  task automatic testLoop();
    doReset();
    step(LDT, 16'd2);
    @(negedge clk);
    loopStart = 1'b1; loopCount = 8'd4; opCode = LDT; dataIn = 16'd1;
    @(posedge clk); #1;
    check("R11 acc i1", accOut, 32'd0);
    check("R11 prod i1", prodOut, 32'd2);
    check("R11 busy i1", {31'b0, loopBusy}, 32'h1);
    for (int i = 2; i <= 4; i++) begin
      @(negedge clk);
      loopStart = 1'b1; loopCount = 8'd9; opCode = LDT; dataIn = 16'(i);
      @(posedge clk); #1;
      check($sformatf("R11 prod i%0d", i), prodOut, 32'(2 * i));
      check($sformatf("R11 busy i%0d", i), {31'b0, loopBusy}, (i < 4) ? 32'h1 : 32'h0);
    end
    check("R11 acc i4", accOut, 32'd12);
    step(IDLE, 16'd0);
    check("R11 after loop", prodOut, 32'd8);
    step(ACCP, 16'd0);
    check("R11 drain", accOut, 32'd20);
    step(MUL, 16'd1);
    check("R11 T kept", prodOut, 32'd2);
    @(negedge clk);
    loopStart = 1'b1; loopCount = 8'd0; opCode = MUL; dataIn = 16'd3;
    @(posedge clk); #1;
    check("R11 zero count prod", prodOut, 32'd2);
    check("R11 zero count acc", accOut, 32'd20);
    check("R11 zero count busy", {31'b0, loopBusy}, 32'h0);
    @(negedge clk);
    loopStart = 1'b0;
  endtask

  initial begin
    fork
      begin
        testReset();
        testLoadMul();
        testCorner();
        testAccSub();
        testLoadAcc();
        testSquare();
        testMacStream();
        testOverflow();
        testIdle();
        testLoop();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule